// File: doc/BRIEF.md
# E1 Timeslot Idle and Loopback Substituter

This block sits in the transmit path of an E1 framer. It works on the serial backplane stream, one 8-bit timeslot at a time. A frame-sync pulse aligns a 256-clock bit counter to the 32 timeslots of the frame. Three settings are written over a byte-wide register bus:

- a 32-bit channel-select mask,
- an 8-bit idle code,
- a mode bit.

A timeslot whose mask bit is clear leaves the block unchanged. A timeslot whose mask bit is set is replaced, and the mode bit picks the replacement:

- With the mode bit clear, the timeslot carries the idle code, sent MSB first.
- With the mode bit set, the timeslot carries the byte arriving at the same moment from the receive-side framer. This is per-channel loopback.

Loopback needs the receive and transmit streams to share one clock and one frame sync, and this block assumes both.

The settings are captured at the first bit of each timeslot and held for its 8 bits. A register write therefore never splits a byte. The output is registered, so every path has a latency of one clock.

Top module: `e1_slot_sub`

## Requirements
- R1: After reset every register reads 0x00, and the output carries the backplane input, delayed by one clock, in every timeslot.
- R2: The register map is as follows:
  - 0x26 to 0x29 hold the mask bytes.
  - 0x2A holds the idle code.
  - 0x2B holds the mode bit in bit 5.

  Every written value reads back, except that bits 7:6 and 4:0 of 0x2B always read 0. Writes and reads at any other address are ignored and read 0x00.
- R3: Channel n (1 to 32) is selected by bit (n-1) mod 8 of the register at address 0x26 + (n-1)/8.
- R4: With the mode bit at 0, each bit of a selected timeslot is the idle code, sent MSB first (idle bit 7 on the first bit of the timeslot).
- R5: Each bit of an unselected timeslot equals the backplane input bit, in either mode.
- R6: With the mode bit at 1, each bit of a selected timeslot equals the receive-side input bit.
- R7: The clock after a sampled frame-sync pulse carries bit 1 (the MSB) of channel 1. The timeslot advances every 8 clocks, and the count wraps to channel 1 after 256 clocks with no new pulse. A pulse that arrives early resynchronises the count.
- R8: The mask bit, the mode bit and the idle code are captured at the first bit of each timeslot. A write at any later bit takes effect from the next timeslot. A write on the edge of the first bit takes effect from the next timeslot as well.
- R9: The output bit for the inputs sampled at one rising edge appears after that edge and holds until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared transmit/receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse; the next clock is channel 1, MSB |
| bp_in | input | 1 | Backplane serial data |
| rx_in | input | 1 | Receive-side framer serial data |
| line_out | output | 1 | Serial data toward the line |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |

## Verification
Read data depends on the address alone, so the bench checks it 1 ns after setting the address, in the same cycle. A write is visible from the next cycle.

The serial output bit for the inputs sampled at rising edge k is due right after that edge. The bench drives inputs on falling edges and computes the expected bit at each rising edge. It compares that bit at the next falling edge.

The expected bit comes from a model of the frame position and the per-timeslot capture. For that reason, a write landing mid-timeslot is judged against the settings in force at the first bit of that timeslot. Each check is tagged with the requirement its timeslot class exercises.

// File: rtl/e1_slot_sub.sv
module e1_slot_sub #(
  parameter int NCH   = 32,
  parameter int SLOTW = 8,
  parameter logic [7:0] MASK_BASE = 8'h26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync,
  input  logic       bp_in,
  input  logic       rx_in,
  output logic       line_out,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata
);
  localparam int NBYTE = NCH / 8;
  localparam int BW    = $clog2(SLOTW);
  localparam int CW    = $clog2(NCH);
  localparam int PW    = BW + CW;
  localparam logic [7:0] IDLE_ADDR = MASK_BASE + 8'(NBYTE);
  localparam logic [7:0] CTRL_ADDR = MASK_BASE + 8'(NBYTE) + 8'd1;
  localparam int MODE_BIT = 5;

  logic [NCH-1:0]   chan_sel;
  logic [SLOTW-1:0] idle_code;
  logic             loop_mode;
  logic [PW-1:0]    pos;
  logic             sel_q, mode_q;
  logic [SLOTW-1:0] idle_q;

  wire [BW-1:0] bit_idx = pos[BW-1:0];
  wire [CW-1:0] ch_idx  = pos[PW-1:BW];
  wire          slot_start = (bit_idx == '0);

  wire             sel_now  = slot_start ? chan_sel[ch_idx] : sel_q;
  wire             mode_now = slot_start ? loop_mode : mode_q;
  wire [SLOTW-1:0] idle_now = slot_start ? idle_code : idle_q;
  wire             idle_bit = idle_now[BW'(SLOTW-1) - bit_idx];
  wire             next_bit = !sel_now ? bp_in : (mode_now ? rx_in : idle_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else if (fsync) pos <= '0;
    else pos <= pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0; mode_q <= 1'b0; idle_q <= '0;
    end else if (slot_start) begin
      sel_q <= sel_now; mode_q <= mode_now; idle_q <= idle_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_out <= 1'b0;
    else line_out <= next_bit;
  end

  generate
    for (genvar b = 0; b < NBYTE; b++) begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n) chan_sel[b*8 +: 8] <= '0;
        else if (reg_we && reg_addr == MASK_BASE + 8'(b)) chan_sel[b*8 +: 8] <= reg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_code <= '0; loop_mode <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == IDLE_ADDR) idle_code <= reg_wdata[SLOTW-1:0];
      if (reg_addr == CTRL_ADDR) loop_mode <= reg_wdata[MODE_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBYTE; b++)
      if (reg_addr == MASK_BASE + 8'(b)) reg_rdata = chan_sel[b*8 +: 8];
    if (reg_addr == IDLE_ADDR) reg_rdata = 8'(idle_code);
    if (reg_addr == CTRL_ADDR) reg_rdata[MODE_BIT] = loop_mode;
  end

  p_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (pos == '0));
  p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> ($stable(sel_q) && $stable(mode_q) && $stable(idle_q)));
  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_start && !sel_q) |=> (line_out == $past(bp_in)));
  p_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_start && sel_q && mode_q) |=> (line_out == $past(rx_in)));
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_ADDR) |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[4:0] == 5'b0));
endmodule

// File: tb/tb_e1_slot_sub.sv
module tb_e1_slot_sub;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, fsync = 0, bp_in = 0, rx_in = 0, reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic line_out;
  logic [7:0] reg_rdata;

  int errors = 0, checks = 0;

  e1_slot_sub dut (.clk, .rst_n, .fsync, .bp_in, .rx_in, .line_out,
                   .reg_addr, .reg_wdata, .reg_we, .reg_rdata);

  always #(CLK_NS/2) clk = ~clk;

  logic [31:0] m_mask;
  logic [7:0]  m_idle;
  logic        m_mode;
  logic [7:0]  m_pos;
  logic        s_sel, s_mode, midw;
  logic [7:0]  s_idle;
  logic        exp_bit, exp_ok;
  string       exp_tag;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a >= 8'h26 && a <= 8'h29) return m_mask[(a-8'h26)*8 +: 8];
    if (a == 8'h2A) return m_idle;
    if (a == 8'h2B) return {2'b00, m_mode, 5'b0};
    return 8'h00;
  endfunction

  function automatic logic model_bit(input logic sel, input logic md, input logic [7:0] idl,
                                     input logic [2:0] b, input logic bp, input logic rx);
    if (!sel) return bp;
    if (md) return rx;
    return idl[7 - b];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_idle = 0; m_mode = 0; m_pos = 0;
      s_sel = 0; s_mode = 0; s_idle = 0; midw = 0; exp_ok = 0;
    end else begin
      if (m_pos[2:0] == 0) begin
        s_sel = m_mask[m_pos[7:3]]; s_mode = m_mode; s_idle = m_idle; midw = 0;
      end
      exp_bit = model_bit(s_sel, s_mode, s_idle, m_pos[2:0], bp_in, rx_in);
      exp_tag = !s_sel ? "R5" : (s_mode ? "R6 R3" : "R4 R3");
      if (m_pos == 0) exp_tag = {exp_tag, " R7"};
      if (midw) exp_tag = {exp_tag, " R8"};
      if (m_mask == 0 && m_idle == 0 && !m_mode) exp_tag = {exp_tag, " R1"};
      exp_tag = {exp_tag, " R9"};
      m_pos = fsync ? 8'd0 : m_pos + 8'd1;
      if (reg_we) begin
        if (reg_addr >= 8'h26 && reg_addr <= 8'h29) m_mask[(reg_addr-8'h26)*8 +: 8] = reg_wdata;
        if (reg_addr == 8'h2A) m_idle = reg_wdata;
        if (reg_addr == 8'h2B) m_mode = reg_wdata[5];
        midw = 1;
      end
      exp_ok = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && exp_ok) begin
      checks++;
      if (line_out !== exp_bit) begin
        errors++;
        $display("FAIL %s pos=%0d line_out=%b expected=%b", exp_tag, m_pos, line_out, exp_bit);
      end
    end
  end

  task automatic chk_read(input logic [7:0] a, input string tag);
    @(negedge clk); reg_we = 0; reg_addr = a; #1;
    checks++;
    if (reg_rdata !== model_read(a)) begin
      errors++;
      $display("FAIL %s read 0x%h got=0x%h expected=0x%h", tag, a, reg_rdata, model_read(a));
    end
  endtask

  int fcnt = 0;
  task automatic step(input bit do_we, input logic [7:0] a, input logic [7:0] d, input bit early);
    @(negedge clk);
    fcnt = (fcnt + 1) % 256;
    fsync = (fcnt == 0) || early;
    if (early) fcnt = 0;
    bp_in = 1'($urandom); rx_in = 1'($urandom);
    reg_we = do_we; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1, a, d, 0);
  endtask

  task automatic run(input int n, input int wrate);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = 8'h26 + 8'($urandom_range(0, 5));
      if ($urandom_range(0, 30) == 0) a = 8'h31;
      step(($urandom_range(0, wrate) == 0), a, 8'($urandom), ($urandom_range(0, 3000) == 0));
    end
  endtask

  initial begin
    void'($urandom(1354));
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int a = 8'h26; a <= 8'h2B; a++) chk_read(8'(a), "R1");
    run(300, 1000000);
    wr(8'h2B, 8'hFF); chk_read(8'h2B, "R2");
    wr(8'h31, 8'hAA); chk_read(8'h31, "R2");
    for (int a = 8'h26; a <= 8'h2A; a++) begin
      wr(8'(a), 8'($urandom)); chk_read(8'(a), "R2");
    end
    wr(8'h2B, 8'h00);
    for (int n = 0; n < 32; n += 9) begin
      for (int b = 0; b < 4; b++) wr(8'h26 + 8'(b), (n / 8 == b) ? 8'(1 << (n % 8)) : 8'h00);
      wr(8'h2A, 8'hA5);
      run(520, 1000000);
    end
    wr(8'h26, 8'hFF); wr(8'h27, 8'hFF); wr(8'h28, 8'hFF); wr(8'h29, 8'hFF);
    run(520, 1000000);
    wr(8'h2B, 8'h20);
    run(520, 1000000);
    wr(8'h2B, 8'h00); wr(8'h2A, 8'h3C);
    for (int i = 0; i < 100; i++) begin
      wr(8'h2A, 8'($urandom));
      wr(8'h2B, 8'($urandom));
      run($urandom_range(0, 9), 1000000);
    end
    run(20000, 20);
    for (int a = 8'h26; a <= 8'h2B; a++) chk_read(8'(a), "R2");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule